// File: doc/BRIEF.md
# PCI function configuration state controller

This block keeps the lifecycle state of a small table of PCI functions, one slot per function, each slot holding one of six states. A function is identified by a function ID supplied per slot. Requests arrive on a valid/ready port carrying an operation (configure or deconfigure) and a function ID. The ID is compared against every slot at once, and the block answers each accepted request with a 16-bit response code one cycle later. A reset sweep input, error reports from the address translation unit and a state-load port used by the surrounding enable and hotplug logic also move the slots.

Slot states and their 3-bit codes are: reserved (0), standby (1), disabled (2), enabled (3), blocked (4) and error (5). The transitions are as follows. Configure moves standby to disabled. Deconfigure moves disabled, enabled, blocked or error to standby. The sweep moves disabled, enabled, blocked or error to disabled. An error report moves any state to error. A load moves a slot to the loaded state. A successful deconfigure also sends one-cycle teardown strobes for interrupt and translation registration, and it sends an unplug strobe when an unplug is pending for that slot.

Top module: `fn_cfg_ctrl`

## Requirements
- R1: A request whose function ID matches no slot answers 0x09F0 and changes no slot. When several slots hold the same ID, the lowest-numbered slot is the one served.
- R2: Configure on a reserved slot answers 0x0AF0 and leaves the slot reserved.
- R3: Configure on a standby slot answers 0x0020 and moves the slot to disabled.
- R4: Configure on a disabled, enabled, blocked or error slot answers 0x0120 and leaves the state unchanged.
- R5: Deconfigure on a reserved slot answers 0x0AF0, and on a standby slot it answers 0x0120. In both cases the state is unchanged and no strobe fires.
- R6: Deconfigure on a disabled, enabled, blocked or error slot answers 0x0020, moves the slot to standby and clears its handle-enable bit.
- R7: A successful deconfigure pulses the slot's interrupt-teardown strobe if its interrupt indicator input is set, and its translation-teardown strobe if its translation-enabled input is set. Each pulse lasts one cycle, in the same cycle as the response.
- R8: A successful deconfigure on a slot whose unplug-request input is set pulses that slot's unplug strobe for one cycle, in the same cycle as the response.
- R9: A sweep cycle leaves reserved and standby slots as they are. It moves every other slot to disabled and clears that slot's handle-enable bit.
- R10: An error report naming a slot forces that slot into the error state on the next edge.
- R11: req_ready is low during a sweep cycle, so no request is taken then. rsp_valid rises for exactly one cycle, on the edge after acceptance.
- R12: After rst_n every slot is reserved with handle-enable clear, and rsp_valid is low. A load writes the given state code to a slot and sets handle-enable exactly when that code is enabled (3). A load of code 6 or 7 is ignored.
- R13: Within a slot the sweep takes precedence over an error report, an error report over a request, and a request over a load. A response always reflects the state the slot held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (low during sweep) |
| req_op_i | input | 1 | 0 = configure, 1 = deconfigure |
| req_fid_i | input | FID_W (8) | Function ID of the request |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_code_o | output | RESP_W (16) | Response code |
| slot_fid_i | input | N_SLOTS*FID_W (32) | Function ID per slot, slot i at bits [i*FID_W +: FID_W] |
| ld_valid_i | input | 1 | State load strobe |
| ld_slot_i | input | IDX_W (2) | Slot to load |
| ld_state_i | input | 3 | State code to load |
| err_valid_i | input | 1 | Translation error report |
| err_slot_i | input | IDX_W (2) | Slot named by the error |
| sweep_i | input | 1 | Reset sweep, one cycle |
| irq_reg_i | input | N_SLOTS (4) | Interrupt indicator registered, per slot |
| xlat_en_i | input | N_SLOTS (4) | Translation enabled, per slot |
| unplug_req_i | input | N_SLOTS (4) | Unplug pending, per slot |
| slot_state_o | output | N_SLOTS*3 (12) | State code per slot, slot i at bits [3i +: 3] |
| hdl_en_o | output | N_SLOTS (4) | Handle-enable bit per slot |
| irq_td_o | output | N_SLOTS (4) | Interrupt teardown strobe per slot |
| xlat_td_o | output | N_SLOTS (4) | Translation teardown strobe per slot |
| unplug_o | output | N_SLOTS (4) | Unplug strobe per slot |

## Verification
The bench runs both operations against every state. A design that mixed up the two asymmetric tables would answer 0x0120 where 0x0020 belongs, or would move a standby slot on deconfigure. Two slots share one ID, which catches a lookup that serves the highest match or updates both slots. Sweep, error and request are applied to the same slot in the same cycle to check the precedence: a wrong order leaves a slot in error after a sweep, or answers from the post-error state. Strobes are checked with their enabling inputs set while the operation fails, so strobes gated on the request alone would show up.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        FS_RSV = 3'd0,
        FS_STB = 3'd1,
        FS_DIS = 3'd2,
        FS_ENA = 3'd3,
        FS_BLK = 3'd4,
        FS_ERR = 3'd5
    } fstate_e;

    typedef enum logic {
        OP_CFG = 1'b0,
        OP_DCF = 1'b1
    } op_e;

    function automatic logic is_legal(input logic [ST_W-1:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic is_live(input fstate_e st);
        return (st != FS_RSV) && (st != FS_STB);
    endfunction

endpackage

// File: rtl/fcs_match.sv
module fcs_match #(
    parameter int N     = 4,
    parameter int FID_W = 8,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FID_W-1:0]     fid_i,
    input  logic [N*FID_W-1:0]   tbl_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o
);

    logic [N-1:0] eq;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign eq[g] = (tbl_i[g*FID_W +: FID_W] == fid_i);
        end
    endgenerate

    always_comb begin
        hit_o = |eq;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    logic [N-1:0] below_mask;
    assign below_mask = (N'(1) << idx_o) - N'(1);

    // R1: the served slot is the lowest index that compares equal
    p_lowest_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (eq[idx_o] && ((eq & below_mask) == '0)));

endmodule

// File: rtl/fcs_slot.sv
module fcs_slot
    import fcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sweep_i,
    input  logic            err_i,
    input  logic            cfg_i,
    input  logic            dcf_i,
    input  logic            ld_i,
    input  logic [ST_W-1:0] ld_state_i,
    input  logic            irq_reg_i,
    input  logic            xlat_en_i,
    input  logic            unplug_req_i,
    output logic [ST_W-1:0] state_o,
    output logic            hdl_en_o,
    output logic            irq_td_o,
    output logic            xlat_td_o,
    output logic            unplug_o
);

    fstate_e st_q, st_n;
    logic    hen_q, hen_n;
    logic    dcf_ok;

    // next-state decision, precedence sweep > error > request > load
    always_comb begin
        st_n  = st_q;
        hen_n = hen_q;
        if (sweep_i) begin
            unique case (st_q)
                FS_RSV, FS_STB: ;
                default: begin
                    st_n  = FS_DIS;
                    hen_n = 1'b0;
                end
            endcase
        end else if (err_i) begin
            st_n = FS_ERR;
        end else if (cfg_i) begin
            unique case (st_q)
                FS_STB:  st_n = FS_DIS;
                default: ;
            endcase
        end else if (dcf_i) begin
            unique case (st_q)
                FS_RSV, FS_STB: ;
                default: begin
                    st_n  = FS_STB;
                    hen_n = 1'b0;
                end
            endcase
        end else if (ld_i && is_legal(ld_state_i)) begin
            st_n  = fstate_e'(ld_state_i);
            hen_n = (fstate_e'(ld_state_i) == FS_ENA);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FS_RSV;
            hen_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            hen_q <= hen_n;
        end
    end

    // output strobes
    assign dcf_ok = dcf_i && is_live(st_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_td_o  <= 1'b0;
            xlat_td_o <= 1'b0;
            unplug_o  <= 1'b0;
        end else begin
            irq_td_o  <= dcf_ok && irq_reg_i;
            xlat_td_o <= dcf_ok && xlat_en_i;
            unplug_o  <= dcf_ok && unplug_req_i;
        end
    end

    assign state_o  = st_q;
    assign hdl_en_o = hen_q;

    // R12: only legal codes are ever held
    p_state_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        is_legal(state_o));

    // R9: after a sweep no slot is live except disabled, and enable is clear
    p_sweep_quiesce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_i |=> ((state_o == FS_RSV || state_o == FS_STB || state_o == FS_DIS) && !hdl_en_o));

    // R10: an error report without a sweep lands in error
    p_err_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !sweep_i) |=> (state_o == FS_ERR));

    // R3: configure moves standby to disabled
    p_cfg_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i && !err_i && !sweep_i && st_q == FS_STB) |=> (state_o == FS_DIS));

    // R6: successful deconfigure lands in standby with enable clear
    p_dcf_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dcf_i && !err_i && !sweep_i && is_live(st_q)) |=> (state_o == FS_STB && !hdl_en_o));

endmodule

// File: rtl/fcs_resp.sv
module fcs_resp
    import fcs_pkg::*;
#(
    parameter int               RESP_W    = 16,
    parameter logic [RESP_W-1:0] RC_NORMAL = 16'h0020,
    parameter logic [RESP_W-1:0] RC_NOACT  = 16'h0120,
    parameter logic [RESP_W-1:0] RC_NOTREC = 16'h09F0,
    parameter logic [RESP_W-1:0] RC_RESV   = 16'h0AF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  op_e               op_i,
    input  logic              hit_i,
    input  fstate_e           st_i,
    output logic              rsp_valid_o,
    output logic [RESP_W-1:0] rsp_code_o
);

    logic [RESP_W-1:0] code_n;

    always_comb begin
        code_n = RC_NOTREC;
        if (hit_i) begin
            if (op_i == OP_CFG) begin
                unique case (st_i)
                    FS_RSV:  code_n = RC_RESV;
                    FS_STB:  code_n = RC_NORMAL;
                    default: code_n = RC_NOACT;
                endcase
            end else begin
                unique case (st_i)
                    FS_RSV:  code_n = RC_RESV;
                    FS_STB:  code_n = RC_NOACT;
                    default: code_n = RC_NORMAL;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_code_o  <= '0;
        end else begin
            rsp_valid_o <= fire_i;
            if (fire_i) begin
                rsp_code_o <= code_n;
            end
        end
    end

    // R11: one response per accepted request
    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> rsp_valid_o);

endmodule

// File: rtl/fn_cfg_ctrl.sv
module fn_cfg_ctrl
    import fcs_pkg::*;
#(
    parameter int                N_SLOTS   = 4,
    parameter int                FID_W     = 8,
    parameter int                RESP_W    = 16,
    parameter logic [RESP_W-1:0] RC_NORMAL = 16'h0020,
    parameter logic [RESP_W-1:0] RC_NOACT  = 16'h0120,
    parameter logic [RESP_W-1:0] RC_NOTREC = 16'h09F0,
    parameter logic [RESP_W-1:0] RC_RESV   = 16'h0AF0,
    localparam int               IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic                     req_op_i,
    input  logic [FID_W-1:0]         req_fid_i,
    output logic                     rsp_valid_o,
    output logic [RESP_W-1:0]        rsp_code_o,
    input  logic [N_SLOTS*FID_W-1:0] slot_fid_i,
    input  logic                     ld_valid_i,
    input  logic [IDX_W-1:0]         ld_slot_i,
    input  logic [ST_W-1:0]          ld_state_i,
    input  logic                     err_valid_i,
    input  logic [IDX_W-1:0]         err_slot_i,
    input  logic                     sweep_i,
    input  logic [N_SLOTS-1:0]       irq_reg_i,
    input  logic [N_SLOTS-1:0]       xlat_en_i,
    input  logic [N_SLOTS-1:0]       unplug_req_i,
    output logic [N_SLOTS*ST_W-1:0]  slot_state_o,
    output logic [N_SLOTS-1:0]       hdl_en_o,
    output logic [N_SLOTS-1:0]       irq_td_o,
    output logic [N_SLOTS-1:0]       xlat_td_o,
    output logic [N_SLOTS-1:0]       unplug_o
);

    logic             fire;
    logic             hit;
    logic [IDX_W-1:0] idx;
    fstate_e          sel_st;
    op_e              op;

    assign req_ready_o = !sweep_i;
    assign fire        = req_valid_i && req_ready_o;
    assign op          = op_e'(req_op_i);

    fcs_match #(
        .N     (N_SLOTS),
        .FID_W (FID_W),
        .IDX_W (IDX_W)
    ) match_i (
        .clk   (clk),
        .rst_n (rst_n),
        .fid_i (req_fid_i),
        .tbl_i (slot_fid_i),
        .hit_o (hit),
        .idx_o (idx)
    );

    generate
        for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
            logic sel;
            assign sel = fire && hit && (idx == IDX_W'(g));

            fcs_slot slot_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .sweep_i      (sweep_i),
                .err_i        (err_valid_i && (err_slot_i == IDX_W'(g))),
                .cfg_i        (sel && (op == OP_CFG)),
                .dcf_i        (sel && (op == OP_DCF)),
                .ld_i         (ld_valid_i && (ld_slot_i == IDX_W'(g))),
                .ld_state_i   (ld_state_i),
                .irq_reg_i    (irq_reg_i[g]),
                .xlat_en_i    (xlat_en_i[g]),
                .unplug_req_i (unplug_req_i[g]),
                .state_o      (slot_state_o[g*ST_W +: ST_W]),
                .hdl_en_o     (hdl_en_o[g]),
                .irq_td_o     (irq_td_o[g]),
                .xlat_td_o    (xlat_td_o[g]),
                .unplug_o     (unplug_o[g])
            );
        end
    endgenerate

    assign sel_st = fstate_e'(slot_state_o[idx*ST_W +: ST_W]);

    fcs_resp #(
        .RESP_W    (RESP_W),
        .RC_NORMAL (RC_NORMAL),
        .RC_NOACT  (RC_NOACT),
        .RC_NOTREC (RC_NOTREC),
        .RC_RESV   (RC_RESV)
    ) resp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .op_i        (op),
        .hit_i       (hit),
        .st_i        (sel_st),
        .rsp_valid_o (rsp_valid_o),
        .rsp_code_o  (rsp_code_o)
    );

    // R7: teardown strobes only accompany a normal-completion response
    p_teardown_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_td_o) || (|xlat_td_o)) |-> (rsp_valid_o && rsp_code_o == RC_NORMAL));

    // R8: unplug strobe only with a normal-completion response
    p_unplug_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|unplug_o) |-> (rsp_valid_o && rsp_code_o == RC_NORMAL));

    // R11: a response lasts one cycle unless another request was taken
    p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !fire) |=> !rsp_valid_o);

    // R1: a miss answers not-recognized
    p_miss_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hit) |=> (rsp_code_o == RC_NOTREC));

    // R11: no more than one strobe set in flight at a time
    p_one_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_td_o | xlat_td_o | unplug_o));

endmodule

// File: tb/fn_cfg_ctrl_tb.sv
module fn_cfg_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int N     = 4;

    typedef struct packed {
        logic [2:0]  ld;
        logic        dcf;
        logic        irq;
        logic        xl;
        logic        up;
        logic [15:0] code;
        logic [2:0]  st;
        logic        eirq;
        logic        exl;
        logic        eup;
    } vec_t;

    // state codes: 0 rsv 1 stb 2 dis 3 ena 4 blk 5 err
    localparam vec_t VECS [12] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0AF0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0020, 3'd2, 1'b0, 1'b0, 1'b0},
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0120, 3'd2, 1'b0, 1'b0, 1'b0},
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0120, 3'd3, 1'b0, 1'b0, 1'b0},
        '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0120, 3'd5, 1'b0, 1'b0, 1'b0},
        '{3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0AF0, 3'd0, 1'b0, 1'b0, 1'b0},
        '{3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0120, 3'd1, 1'b0, 1'b0, 1'b0},
        '{3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0020, 3'd1, 1'b1, 1'b0, 1'b0},
        '{3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0020, 3'd1, 1'b0, 1'b1, 1'b1},
        '{3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0020, 3'd1, 1'b1, 1'b1, 1'b1},
        '{3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0020, 3'd1, 1'b0, 1'b0, 1'b0},
        '{3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0120, 3'd3, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [7:0]  req_fid = '0;
    logic        rsp_valid;
    logic [15:0] rsp_code;
    logic [31:0] slot_fid = {8'h10, 8'h32, 8'h21, 8'h10};
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_slot = '0;
    logic [2:0]  ld_state = '0;
    logic        err_valid = 1'b0;
    logic [1:0]  err_slot = '0;
    logic        sweep = 1'b0;
    logic [3:0]  irq_reg = '0;
    logic [3:0]  xlat_en = '0;
    logic [3:0]  unplug_req = '0;
    logic [11:0] slot_state;
    logic [3:0]  hdl_en;
    logic [3:0]  irq_td;
    logic [3:0]  xlat_td;
    logic [3:0]  unplug;

    int total = 0;
    int bad   = 0;

    always #(CLK_P / 2) clk = ~clk;

    fn_cfg_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_op_i     (req_op),
        .req_fid_i    (req_fid),
        .rsp_valid_o  (rsp_valid),
        .rsp_code_o   (rsp_code),
        .slot_fid_i   (slot_fid),
        .ld_valid_i   (ld_valid),
        .ld_slot_i    (ld_slot),
        .ld_state_i   (ld_state),
        .err_valid_i  (err_valid),
        .err_slot_i   (err_slot),
        .sweep_i      (sweep),
        .irq_reg_i    (irq_reg),
        .xlat_en_i    (xlat_en),
        .unplug_req_i (unplug_req),
        .slot_state_o (slot_state),
        .hdl_en_o     (hdl_en),
        .irq_td_o     (irq_td),
        .xlat_td_o    (xlat_td),
        .unplug_o     (unplug)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] st_of(input int s);
        return slot_state[3*s +: 3];
    endfunction

    task automatic load(input int s, input logic [2:0] code);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_slot  = 2'(s);
        ld_state = code;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // drive at negedge, response sampled at the following negedge
    task automatic send(input logic op, input logic [7:0] fid);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_fid   = fid;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic string tag_of(input vec_t v);
        if (!v.dcf) begin
            if (v.ld == 3'd0) return "R2";
            if (v.ld == 3'd1) return "R3";
            return "R4";
        end
        if (v.ld <= 3'd1) return "R5";
        return "R6";
    endfunction

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(slot_state == 12'h000, "R12 reset states", 32'(slot_state), 32'h0);
        chk(hdl_en == 4'h0, "R12 reset enable", 32'(hdl_en), 32'h0);
        chk(!rsp_valid, "R12 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk(req_ready, "R11 ready idle", 32'(req_ready), 32'h1);

        // table walk on slot 1 (fid 0x21)
        for (int k = 0; k < 12; k++) begin
            vec_t v;
            string t;
            v = VECS[k];
            t = tag_of(v);
            load(1, v.ld);
            irq_reg[1]    = v.irq;
            xlat_en[1]    = v.xl;
            unplug_req[1] = v.up;
            send(v.dcf, 8'h21);
            chk(rsp_valid, {t, " rsp_valid"}, 32'(rsp_valid), 32'h1);
            chk(rsp_code == v.code, {t, " code"}, 32'(rsp_code), 32'(v.code));
            chk(st_of(1) == v.st, {t, " state"}, 32'(st_of(1)), 32'(v.st));
            chk(hdl_en[1] == (v.st == 3'd3), {t, " R6 enable"}, 32'(hdl_en[1]), 32'(v.st == 3'd3));
            chk(irq_td == {2'b0, v.eirq, 1'b0}, "R7 irq teardown", 32'(irq_td), 32'({v.eirq, 1'b0}));
            chk(xlat_td == {2'b0, v.exl, 1'b0}, "R7 xlat teardown", 32'(xlat_td), 32'({v.exl, 1'b0}));
            chk(unplug == {2'b0, v.eup, 1'b0}, "R8 unplug", 32'(unplug), 32'({v.eup, 1'b0}));
            @(negedge clk);
            chk(!rsp_valid, "R11 rsp one cycle", 32'(rsp_valid), 32'h0);
            chk(irq_td == 4'h0 && unplug == 4'h0, "R7 strobe one cycle", 32'(irq_td | unplug), 32'h0);
            irq_reg = '0;
            xlat_en = '0;
            unplug_req = '0;
        end

        // R1 unmatched id
        load(1, 3'd1);
        send(1'b0, 8'h7F);
        chk(rsp_code == 16'h09F0, "R1 miss code", 32'(rsp_code), 32'h09F0);
        chk(st_of(1) == 3'd1, "R1 miss no change", 32'(st_of(1)), 32'h1);

        // R1 duplicate id: slot 0 and slot 3 both 0x10
        load(0, 3'd1);
        load(3, 3'd1);
        send(1'b0, 8'h10);
        chk(rsp_code == 16'h0020, "R1 dup code", 32'(rsp_code), 32'h0020);
        chk(st_of(0) == 3'd2, "R1 dup low slot", 32'(st_of(0)), 32'h2);
        chk(st_of(3) == 3'd1, "R1 dup high slot", 32'(st_of(3)), 32'h1);

        // R9 sweep, with R11 request blocked
        load(0, 3'd3);
        chk(hdl_en[0], "R12 enable on load", 32'(hdl_en[0]), 32'h1);
        load(1, 3'd1);
        load(2, 3'd5);
        load(3, 3'd0);
        @(negedge clk);
        sweep     = 1'b1;
        req_valid = 1'b1;
        req_op    = 1'b0;
        req_fid   = 8'h21;
        #1;
        chk(!req_ready, "R11 ready in sweep", 32'(req_ready), 32'h0);
        @(negedge clk);
        sweep     = 1'b0;
        req_valid = 1'b0;
        chk(!rsp_valid, "R11 no accept in sweep", 32'(rsp_valid), 32'h0);
        chk(slot_state == {3'd0, 3'd2, 3'd1, 3'd2}, "R9 sweep states", 32'(slot_state),
            32'({3'd0, 3'd2, 3'd1, 3'd2}));
        chk(hdl_en == 4'h0, "R9 sweep enable", 32'(hdl_en), 32'h0);

        // R10 error report
        load(2, 3'd4);
        @(negedge clk);
        err_valid = 1'b1;
        err_slot  = 2'd2;
        @(negedge clk);
        err_valid = 1'b0;
        chk(st_of(2) == 3'd5, "R10 error state", 32'(st_of(2)), 32'h5);

        // R12 illegal load ignored
        load(2, 3'd7);
        chk(st_of(2) == 3'd5, "R12 illegal load", 32'(st_of(2)), 32'h5);

        // R13 error beats request, response from prior state
        load(1, 3'd1);
        @(negedge clk);
        err_valid = 1'b1;
        err_slot  = 2'd1;
        req_valid = 1'b1;
        req_op    = 1'b0;
        req_fid   = 8'h21;
        @(negedge clk);
        err_valid = 1'b0;
        req_valid = 1'b0;
        chk(rsp_code == 16'h0020, "R13 code from prior state", 32'(rsp_code), 32'h0020);
        chk(st_of(1) == 3'd5, "R13 error over request", 32'(st_of(1)), 32'h5);

        // R13 sweep beats error
        load(2, 3'd3);
        @(negedge clk);
        sweep     = 1'b1;
        err_valid = 1'b1;
        err_slot  = 2'd2;
        @(negedge clk);
        sweep     = 1'b0;
        err_valid = 1'b0;
        chk(st_of(2) == 3'd2, "R13 sweep over error", 32'(st_of(2)), 32'h2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule